// File: doc/BRIEF.md
# Multicycle Core Sequencer

This block is the control sequencer for a small multicycle processor core. The core uses one memory for both instructions and data and keeps operands in holding registers (x, y, z and a data register) from one cycle to the next. The sequencer watches three things: the opcode and function fields of the instruction register, and the ALU zero and sign flags. From these, and from its own state, it drives every datapath control for the current cycle. These controls are the program-counter write and its source, the jump-target select, the memory address select, memory read and write, instruction-register load, register-file write with its destination and writeback source, the two ALU operand selects, and a five-bit ALU function word.

Every instruction begins with two shared cycles. The fetch cycle loads the instruction and advances the PC. The decode cycle reads the operands and computes a branch target in advance, before the instruction class is known. After decode the path splits by class, so an instruction takes three, four or five cycles in total. A conditional branch writes the PC only when the ALU flags satisfy its condition. The current state is brought out as a four-bit code for observation.

Top module: `mc_ctrl_fsm`

## Requirements
- R1: State codes are fetch 0, decode 1, address 2, load-read 3, load-writeback 4, transfer 5, store 6, execute 7, execute-writeback 8. While reset is held, and on the first cycle after it is released, the state is fetch. A reset asserted in the middle of an instruction returns the sequencer to fetch.
- R2: The fetch state sets the address select to 0, asserts memory read and IR write, sets ALU X source 0 and Y source 0 with the add function, sets PC source 3 and asserts PC write. The next state is always decode.
- R3: The decode state sets X source 0, Y source 3 and add, and asserts no write strobe. An opcode that is not recognised, or an R-format function code that is not recognised, returns the sequencer to fetch after decode, with no write strobe asserted.
- R4: R-format arithmetic and logic instructions (opcode 0; function 32 add, 34 sub, 42 slt, 36 and, 37 or, 38 xor, 39 nor) take 4 cycles. Execute uses X source 1 and Y source 1. Writeback asserts register write with destination 1 (rd) and writeback source 1.
- R5: Immediate ALU instructions (opcodes 15 lui, 8 addi, 10 slti, 12 andi, 13 ori, 14 xori) take 4 cycles. Execute uses X source 1 and Y source 2. Writeback uses destination 0 (rt) and writeback source 1.
- R6: A load (opcode 35) takes 5 cycles. The address state uses X source 1, Y source 2 and add. The load-read state uses address select 1 and memory read. The load-writeback state asserts register write with destination 0 and writeback source 0.
- R7: A store (opcode 43) takes 4 cycles. Its final state uses address select 1 and memory write. Memory write is asserted in no other state.
- R8: Branches (opcodes 4 beq, 5 bne, 1 bltz) take 3 cycles. The transfer state uses X source 1, Y source 1, subtract and PC source 2. PC write equals the zero flag for beq, its inverse for bne, and the sign flag for bltz.
- R9: Jumps take 3 cycles and assert PC write in the transfer state. For j (opcode 2) this is with jump select 0 and PC source 0. For jal (opcode 3) it is the same, and jal also asserts register write with destination 2 (register 31) and writeback source 2 (return address). R-format function 12 (system call) uses jump select 1 and PC source 0. R-format function 8 (register jump) uses PC source 1.
- R10: Register write is asserted only in load-writeback, execute-writeback, and the transfer state of jal. IR write is asserted only in fetch.
- R11: The ALU function word is {class[1:0], subtract, logic[1:0]}. Class is 0 lui, 1 set-less, 2 arithmetic, 3 logic. Logic is 0 and, 1 or, 2 xor, 3 nor. Set-less and subtract set the subtract bit. Unused fields are 0. This gives add 16, sub 20, slt 12, lui 0, and 24, or 25, xor 26, nor 27.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| opcode | input | OP_W | Opcode field of the instruction register |
| funct | input | FN_W | Function field of the instruction register |
| alu_zero | input | 1 | ALU result is zero |
| alu_sign | input | 1 | ALU result bit 31 |
| pc_wr | output | 1 | PC write enable |
| pc_src | output | 2 | PC source: 0 jump target, 1 x register, 2 z register, 3 ALU output |
| jmp_sel | output | 1 | Jump target: 0 instruction target, 1 system-call address |
| addr_sel | output | 1 | Memory address: 0 PC, 1 z register |
| mem_rd | output | 1 | Memory read |
| mem_wr | output | 1 | Memory write |
| ir_wr | output | 1 | Instruction register load |
| reg_wr | output | 1 | Register file write |
| reg_dst | output | 2 | Destination: 0 rt, 1 rd, 2 register 31 |
| wb_src | output | 2 | Writeback data: 0 data register, 1 z register, 2 return address |
| alu_x_sel | output | 1 | ALU X operand: 0 PC, 1 x register |
| alu_y_sel | output | 2 | ALU Y operand: 0 constant 4, 1 y register, 2 immediate, 3 4 times immediate |
| alu_fn | output | 5 | ALU function word |
| state_o | output | 4 | Current state code |

## Verification
The bench steps every opcode and function code through the sequencer. Each cycle it compares the state code and the whole control word against a behavioural model, so a class that stayed one cycle too long or too short shows up as a wrong state in the following cycle.

Each branch is run with its flag condition both met and not met. A swapped or inverted flag would either write the PC on a branch that should not be taken or skip the write on one that should. Register write, memory write and IR write are checked for leakage on every cycle, which exposes a jal that omits the link write or a store that also strobes the register file.

Unknown opcodes and unknown R-format function codes must fall back to fetch with no strobe. A design that decoded them as some default class would start writing. A reset applied in the middle of an instruction must restart the fetch sequence at once.

// File: rtl/mcc_pkg.sv
package mcc_pkg;

   typedef enum logic [3:0] {
      ST_FETCH  = 4'd0,
      ST_DECODE = 4'd1,
      ST_ADDR   = 4'd2,
      ST_LOAD   = 4'd3,
      ST_LDWB   = 4'd4,
      ST_XFER   = 4'd5,
      ST_STORE  = 4'd6,
      ST_EXEC   = 4'd7,
      ST_EXWB   = 4'd8
   } mcc_state_e;

   localparam int NUM_ST  = 9;
   localparam int STATE_W = 4;

   typedef enum logic [3:0] {
      IC_BAD, IC_ALU_R, IC_ALU_I, IC_LOAD, IC_STORE, IC_JUMP,
      IC_LINK, IC_JREG, IC_SYSC, IC_BEQ, IC_BNE, IC_BLTZ
   } mcc_cls_e;

   localparam int ALUFN_W = 5;

   // word layout {class[1:0], subtract, logic[1:0]}
   localparam logic [ALUFN_W-1:0] AF_LUI = 5'b00000;
   localparam logic [ALUFN_W-1:0] AF_SLT = 5'b01100;
   localparam logic [ALUFN_W-1:0] AF_ADD = 5'b10000;
   localparam logic [ALUFN_W-1:0] AF_SUB = 5'b10100;
   localparam logic [ALUFN_W-1:0] AF_AND = 5'b11000;
   localparam logic [ALUFN_W-1:0] AF_OR  = 5'b11001;
   localparam logic [ALUFN_W-1:0] AF_XOR = 5'b11010;
   localparam logic [ALUFN_W-1:0] AF_NOR = 5'b11011;

   localparam logic [5:0] OPC_RFMT = 6'd0;
   localparam logic [5:0] OPC_BLTZ = 6'd1;
   localparam logic [5:0] OPC_J    = 6'd2;
   localparam logic [5:0] OPC_JAL  = 6'd3;
   localparam logic [5:0] OPC_BEQ  = 6'd4;
   localparam logic [5:0] OPC_BNE  = 6'd5;
   localparam logic [5:0] OPC_ADDI = 6'd8;
   localparam logic [5:0] OPC_SLTI = 6'd10;
   localparam logic [5:0] OPC_ANDI = 6'd12;
   localparam logic [5:0] OPC_ORI  = 6'd13;
   localparam logic [5:0] OPC_XORI = 6'd14;
   localparam logic [5:0] OPC_LUI  = 6'd15;
   localparam logic [5:0] OPC_LW   = 6'd35;
   localparam logic [5:0] OPC_SW   = 6'd43;

   localparam logic [5:0] FN_JR   = 6'd8;
   localparam logic [5:0] FN_SYSC = 6'd12;
   localparam logic [5:0] FN_ADD  = 6'd32;
   localparam logic [5:0] FN_SUB  = 6'd34;
   localparam logic [5:0] FN_AND  = 6'd36;
   localparam logic [5:0] FN_OR   = 6'd37;
   localparam logic [5:0] FN_XOR  = 6'd38;
   localparam logic [5:0] FN_NOR  = 6'd39;
   localparam logic [5:0] FN_SLT  = 6'd42;

   typedef struct packed {
      mcc_cls_e            cls;
      logic [ALUFN_W-1:0]  alu_fn;
   } mcc_dec_t;

   typedef struct packed {
      logic               pc_wr;
      logic [1:0]         pc_src;
      logic               jmp_sel;
      logic               addr_sel;
      logic               mem_rd;
      logic               mem_wr;
      logic               ir_wr;
      logic               reg_wr;
      logic [1:0]         reg_dst;
      logic [1:0]         wb_src;
      logic               alu_x_sel;
      logic [1:0]         alu_y_sel;
      logic [ALUFN_W-1:0] alu_fn;
   } mcc_ctrl_t;

endpackage

// File: rtl/mcc_decode.sv
module mcc_decode
   import mcc_pkg::*;
#(
   parameter int OP_W = 6,
   parameter int FN_W = 6
) (
   input  logic [OP_W-1:0] opcode,
   input  logic [FN_W-1:0] funct,
   output mcc_dec_t        dec
);

   logic       op_hi_ok;
   logic       fn_hi_ok;
   logic [5:0] op6;
   logic [5:0] fn6;

   assign op6 = opcode[5:0];
   assign fn6 = funct[5:0];

   // extra upper bits, when present, must be zero for a legal code
   generate
      if (OP_W > 6) begin : g_op_wide
         assign op_hi_ok = ~|opcode[OP_W-1:6];
      end else begin : g_op_exact
         assign op_hi_ok = 1'b1;
      end
      if (FN_W > 6) begin : g_fn_wide
         assign fn_hi_ok = ~|funct[FN_W-1:6];
      end else begin : g_fn_exact
         assign fn_hi_ok = 1'b1;
      end
   endgenerate

   always_comb begin
      dec.cls    = IC_BAD;
      dec.alu_fn = AF_ADD;
      if (op_hi_ok) begin
         case (op6)
            OPC_RFMT: begin
               if (fn_hi_ok) begin
                  case (fn6)
                     FN_ADD:  begin dec.cls = IC_ALU_R; dec.alu_fn = AF_ADD; end
                     FN_SUB:  begin dec.cls = IC_ALU_R; dec.alu_fn = AF_SUB; end
                     FN_SLT:  begin dec.cls = IC_ALU_R; dec.alu_fn = AF_SLT; end
                     FN_AND:  begin dec.cls = IC_ALU_R; dec.alu_fn = AF_AND; end
                     FN_OR:   begin dec.cls = IC_ALU_R; dec.alu_fn = AF_OR;  end
                     FN_XOR:  begin dec.cls = IC_ALU_R; dec.alu_fn = AF_XOR; end
                     FN_NOR:  begin dec.cls = IC_ALU_R; dec.alu_fn = AF_NOR; end
                     FN_JR:   dec.cls = IC_JREG;
                     FN_SYSC: dec.cls = IC_SYSC;
                     default: dec.cls = IC_BAD;
                  endcase
               end
            end
            OPC_LUI:  begin dec.cls = IC_ALU_I; dec.alu_fn = AF_LUI; end
            OPC_ADDI: begin dec.cls = IC_ALU_I; dec.alu_fn = AF_ADD; end
            OPC_SLTI: begin dec.cls = IC_ALU_I; dec.alu_fn = AF_SLT; end
            OPC_ANDI: begin dec.cls = IC_ALU_I; dec.alu_fn = AF_AND; end
            OPC_ORI:  begin dec.cls = IC_ALU_I; dec.alu_fn = AF_OR;  end
            OPC_XORI: begin dec.cls = IC_ALU_I; dec.alu_fn = AF_XOR; end
            OPC_LW:   dec.cls = IC_LOAD;
            OPC_SW:   dec.cls = IC_STORE;
            OPC_J:    dec.cls = IC_JUMP;
            OPC_JAL:  dec.cls = IC_LINK;
            OPC_BEQ:  dec.cls = IC_BEQ;
            OPC_BNE:  dec.cls = IC_BNE;
            OPC_BLTZ: dec.cls = IC_BLTZ;
            default:  dec.cls = IC_BAD;
         endcase
      end
   end

endmodule

// File: rtl/mcc_seq.sv
module mcc_seq
   import mcc_pkg::*;
#(
   parameter bit ONE_HOT = 1'b0
) (
   input  logic       clk,
   input  logic       rst_n,
   input  mcc_cls_e   cls,
   output mcc_state_e st
);

   mcc_state_e nxt;

   always_comb begin
      case (st)
         ST_FETCH:  nxt = ST_DECODE;
         ST_DECODE: begin
            case (cls)
               IC_ALU_R, IC_ALU_I: nxt = ST_EXEC;
               IC_LOAD, IC_STORE:  nxt = ST_ADDR;
               IC_JUMP, IC_LINK, IC_JREG, IC_SYSC,
               IC_BEQ, IC_BNE, IC_BLTZ: nxt = ST_XFER;
               default:            nxt = ST_FETCH;
            endcase
         end
         ST_ADDR:   nxt = (cls == IC_LOAD) ? ST_LOAD : ST_STORE;
         ST_LOAD:   nxt = ST_LDWB;
         ST_EXEC:   nxt = ST_EXWB;
         default:   nxt = ST_FETCH;
      endcase
   end

   generate
      if (ONE_HOT) begin : g_onehot
         logic [NUM_ST-1:0]  oh_q;
         logic [STATE_W-1:0] st_bin;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) oh_q <= NUM_ST'(1);
            else        oh_q <= NUM_ST'(1) << nxt;
         end

         always_comb begin
            st_bin = '0;
            for (int i = 0; i < NUM_ST; i++) begin
               if (oh_q[i]) st_bin = STATE_W'(i);
            end
         end
         assign st = mcc_state_e'(st_bin);

         p_onehot_r1: assert property (@(posedge clk) disable iff (!rst_n)
            $countones(oh_q) == 1)
            else $error("state vector not one-hot");
      end else begin : g_binary
         mcc_state_e st_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) st_q <= ST_FETCH;
            else        st_q <= nxt;
         end
         assign st = st_q;
      end
   endgenerate

   p_fetch_to_decode_r2: assert property (@(posedge clk) disable iff (!rst_n)
      st == ST_FETCH |=> st == ST_DECODE)
      else $error("fetch not followed by decode");

   p_exec_to_wb_r4: assert property (@(posedge clk) disable iff (!rst_n)
      st == ST_EXEC |=> st == ST_EXWB)
      else $error("execute not followed by writeback");

   p_load_to_wb_r6: assert property (@(posedge clk) disable iff (!rst_n)
      st == ST_LOAD |=> st == ST_LDWB)
      else $error("load read not followed by writeback");

   p_wb_ends_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_LDWB || st == ST_EXWB || st == ST_STORE || st == ST_XFER)
      |=> st == ST_FETCH)
      else $error("final state not followed by fetch");

endmodule

// File: rtl/mcc_outgen.sv
module mcc_outgen
   import mcc_pkg::*;
(
   input  mcc_state_e st,
   input  mcc_dec_t   dec,
   input  logic       alu_zero,
   input  logic       alu_sign,
   output mcc_ctrl_t  ctl
);

   always_comb begin
      ctl = '0;
      case (st)
         ST_FETCH: begin
            ctl.addr_sel  = 1'b0;
            ctl.mem_rd    = 1'b1;
            ctl.ir_wr     = 1'b1;
            ctl.alu_x_sel = 1'b0;
            ctl.alu_y_sel = 2'd0;
            ctl.alu_fn    = AF_ADD;
            ctl.pc_src    = 2'd3;
            ctl.pc_wr     = 1'b1;
         end
         ST_DECODE: begin
            ctl.alu_x_sel = 1'b0;
            ctl.alu_y_sel = 2'd3;
            ctl.alu_fn    = AF_ADD;
         end
         ST_EXEC: begin
            ctl.alu_x_sel = 1'b1;
            ctl.alu_y_sel = (dec.cls == IC_ALU_R) ? 2'd1 : 2'd2;
            ctl.alu_fn    = dec.alu_fn;
         end
         ST_EXWB: begin
            ctl.reg_wr  = 1'b1;
            ctl.reg_dst = (dec.cls == IC_ALU_R) ? 2'd1 : 2'd0;
            ctl.wb_src  = 2'd1;
         end
         ST_ADDR: begin
            ctl.alu_x_sel = 1'b1;
            ctl.alu_y_sel = 2'd2;
            ctl.alu_fn    = AF_ADD;
         end
         ST_LOAD: begin
            ctl.addr_sel = 1'b1;
            ctl.mem_rd   = 1'b1;
         end
         ST_LDWB: begin
            ctl.reg_wr  = 1'b1;
            ctl.reg_dst = 2'd0;
            ctl.wb_src  = 2'd0;
         end
         ST_STORE: begin
            ctl.addr_sel = 1'b1;
            ctl.mem_wr   = 1'b1;
         end
         ST_XFER: begin
            ctl.alu_x_sel = 1'b1;
            ctl.alu_y_sel = 2'd1;
            ctl.alu_fn    = AF_SUB;
            case (dec.cls)
               IC_JUMP: begin
                  ctl.pc_wr   = 1'b1;
                  ctl.jmp_sel = 1'b0;
                  ctl.pc_src  = 2'd0;
               end
               IC_LINK: begin
                  ctl.pc_wr   = 1'b1;
                  ctl.jmp_sel = 1'b0;
                  ctl.pc_src  = 2'd0;
                  ctl.reg_wr  = 1'b1;
                  ctl.reg_dst = 2'd2;
                  ctl.wb_src  = 2'd2;
               end
               IC_SYSC: begin
                  ctl.pc_wr   = 1'b1;
                  ctl.jmp_sel = 1'b1;
                  ctl.pc_src  = 2'd0;
               end
               IC_JREG: begin
                  ctl.pc_wr  = 1'b1;
                  ctl.pc_src = 2'd1;
               end
               IC_BEQ: begin
                  ctl.pc_src = 2'd2;
                  ctl.pc_wr  = alu_zero;
               end
               IC_BNE: begin
                  ctl.pc_src = 2'd2;
                  ctl.pc_wr  = ~alu_zero;
               end
               IC_BLTZ: begin
                  ctl.pc_src = 2'd2;
                  ctl.pc_wr  = alu_sign;
               end
               default: ctl.pc_wr = 1'b0;
            endcase
         end
         default: ctl = '0;
      endcase
   end

endmodule

// File: rtl/mc_ctrl_fsm.sv
module mc_ctrl_fsm
   import mcc_pkg::*;
#(
   parameter int OP_W    = 6,
   parameter int FN_W    = 6,
   parameter bit ONE_HOT = 1'b0
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [OP_W-1:0]     opcode,
   input  logic [FN_W-1:0]     funct,
   input  logic                alu_zero,
   input  logic                alu_sign,
   output logic                pc_wr,
   output logic [1:0]          pc_src,
   output logic                jmp_sel,
   output logic                addr_sel,
   output logic                mem_rd,
   output logic                mem_wr,
   output logic                ir_wr,
   output logic                reg_wr,
   output logic [1:0]          reg_dst,
   output logic [1:0]          wb_src,
   output logic                alu_x_sel,
   output logic [1:0]          alu_y_sel,
   output logic [ALUFN_W-1:0]  alu_fn,
   output logic [STATE_W-1:0]  state_o
);

   generate
      if (OP_W < 6) begin : g_bad_op_w
         $error("OP_W must be at least 6");
      end
      if (FN_W < 6) begin : g_bad_fn_w
         $error("FN_W must be at least 6");
      end
   endgenerate

   mcc_dec_t   dec;
   mcc_state_e st;
   mcc_ctrl_t  ctl;

   mcc_decode #(.OP_W(OP_W), .FN_W(FN_W)) u_decode (
      .opcode (opcode),
      .funct  (funct),
      .dec    (dec)
   );

   mcc_seq #(.ONE_HOT(ONE_HOT)) u_seq (
      .clk   (clk),
      .rst_n (rst_n),
      .cls   (dec.cls),
      .st    (st)
   );

   mcc_outgen u_outgen (
      .st       (st),
      .dec      (dec),
      .alu_zero (alu_zero),
      .alu_sign (alu_sign),
      .ctl      (ctl)
   );

   assign pc_wr     = ctl.pc_wr;
   assign pc_src    = ctl.pc_src;
   assign jmp_sel   = ctl.jmp_sel;
   assign addr_sel  = ctl.addr_sel;
   assign mem_rd    = ctl.mem_rd;
   assign mem_wr    = ctl.mem_wr;
   assign ir_wr     = ctl.ir_wr;
   assign reg_wr    = ctl.reg_wr;
   assign reg_dst   = ctl.reg_dst;
   assign wb_src    = ctl.wb_src;
   assign alu_x_sel = ctl.alu_x_sel;
   assign alu_y_sel = ctl.alu_y_sel;
   assign alu_fn    = ctl.alu_fn;
   assign state_o   = st;

   p_irwr_then_decode_r2: assert property (@(posedge clk) disable iff (!rst_n)
      ir_wr |=> state_o == 4'd1)
      else $error("IR load not followed by decode");

   p_memwr_store_r7: assert property (@(posedge clk) disable iff (!rst_n)
      mem_wr |-> (state_o == 4'd6 && addr_sel))
      else $error("memory write outside store state");

   p_memrd_states_r6: assert property (@(posedge clk) disable iff (!rst_n)
      mem_rd |-> (state_o == 4'd0 || state_o == 4'd3))
      else $error("memory read outside fetch or load");

   p_beq_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (state_o == 4'd5 && opcode == OP_W'(4)) |-> (pc_wr == alu_zero))
      else $error("beq PC write not following zero flag");

   p_regwr_states_r10: assert property (@(posedge clk) disable iff (!rst_n)
      reg_wr |-> (state_o == 4'd4 || state_o == 4'd8 ||
                  (state_o == 4'd5 && opcode == OP_W'(3))))
      else $error("register write in wrong state");

endmodule

// File: tb/test_mc_ctrl_fsm.sv
`timescale 1ns/1ps
module test_mc_ctrl_fsm;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [5:0] opcode = '0;
   logic [5:0] funct = '0;
   logic       alu_zero = 1'b0;
   logic       alu_sign = 1'b0;
   logic       pc_wr, jmp_sel, addr_sel, mem_rd, mem_wr, ir_wr, reg_wr, alu_x_sel;
   logic [1:0] pc_src, reg_dst, wb_src, alu_y_sel;
   logic [4:0] alu_fn;
   logic [3:0] state_o;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   always #2.5 clk = ~clk;

   mc_ctrl_fsm i_mc_ctrl_fsm (
      .clk(clk), .rst_n(rst_n), .opcode(opcode), .funct(funct),
      .alu_zero(alu_zero), .alu_sign(alu_sign),
      .pc_wr(pc_wr), .pc_src(pc_src), .jmp_sel(jmp_sel), .addr_sel(addr_sel),
      .mem_rd(mem_rd), .mem_wr(mem_wr), .ir_wr(ir_wr), .reg_wr(reg_wr),
      .reg_dst(reg_dst), .wb_src(wb_src), .alu_x_sel(alu_x_sel),
      .alu_y_sel(alu_y_sel), .alu_fn(alu_fn), .state_o(state_o)
   );

   function automatic logic [20:0] pk(bit pw, int ps, bit js, bit as, bit mr,
                                      bit mw, bit iw, bit rw, int rd, int wb,
                                      bit xs, int ys, int fw);
      return {pw, 2'(ps), js, as, mr, mw, iw, rw, 2'(rd), 2'(wb), xs, 2'(ys), 5'(fw)};
   endfunction

   function automatic logic [20:0] actual();
      return {pc_wr, pc_src, jmp_sel, addr_sel, mem_rd, mem_wr, ir_wr, reg_wr,
              reg_dst, wb_src, alu_x_sel, alu_y_sel, alu_fn};
   endfunction

   // kinds: 0 bad,1 alu-r,2 alu-i,3 lw,4 sw,5 j,6 jal,7 jr,8 sys,9 beq,10 bne,11 bltz
   function automatic int kind(int op, int fn);
      case (op)
         0: case (fn)
               32, 34, 42, 36, 37, 38, 39: return 1;
               8: return 7;
               12: return 8;
               default: return 0;
            endcase
         15, 8, 10, 12, 13, 14: return 2;
         35: return 3;
         43: return 4;
         2: return 5;
         3: return 6;
         4: return 9;
         5: return 10;
         1: return 11;
         default: return 0;
      endcase
   endfunction

   // R11: word = class*8 + subtract*4 + logic
   function automatic int afn(int op, int fn);
      int key;
      key = (op == 0) ? fn : op + 100;
      case (key)
         32, 108: return 2*8;
         34:      return 2*8 + 4;
         42, 110: return 1*8 + 4;
         115:     return 0;
         36, 112: return 3*8 + 0;
         37, 113: return 3*8 + 1;
         38, 114: return 3*8 + 2;
         39:      return 3*8 + 3;
         default: return -1;
      endcase
   endfunction

   function automatic logic [20:0] model(int st, int k, int op, int fn, bit z, bit s);
      case (st)
         0: return pk(1,3,0,0,1,0,1,0,0,0,0,0,16);
         1: return pk(0,0,0,0,0,0,0,0,0,0,0,3,16);
         2: return pk(0,0,0,0,0,0,0,0,0,0,1,2,16);
         3: return pk(0,0,0,1,1,0,0,0,0,0,0,0,0);
         4: return pk(0,0,0,0,0,0,0,1,0,0,0,0,0);
         6: return pk(0,0,0,1,0,1,0,0,0,0,0,0,0);
         7: return pk(0,0,0,0,0,0,0,0,0,0,1,(k == 1) ? 1 : 2, afn(op, fn));
         8: return pk(0,0,0,0,0,0,0,1,(k == 1) ? 1 : 0,1,0,0,0);
         5: case (k)
               5:  return pk(1,0,0,0,0,0,0,0,0,0,1,1,20);
               6:  return pk(1,0,0,0,0,0,0,1,2,2,1,1,20);
               8:  return pk(1,0,1,0,0,0,0,0,0,0,1,1,20);
               7:  return pk(1,1,0,0,0,0,0,0,0,0,1,1,20);
               9:  return pk(z,2,0,0,0,0,0,0,0,0,1,1,20);
               10: return pk(!z,2,0,0,0,0,0,0,0,0,1,1,20);
               default: return pk(s,2,0,0,0,0,0,0,0,0,1,1,20);
            endcase
         default: return '0;
      endcase
   endfunction

   task automatic check(string tag, string what, int act, int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
      end
   endtask

   // called at a negedge while the design sits in fetch
   task automatic run_instr(int op, int fn, bit z, bit s, string tag);
      int k;
      int seq[$];
      k = kind(op, fn);
      opcode = 6'(op); funct = 6'(fn); alu_zero = z; alu_sign = s;
      seq = {0, 1};
      case (k)
         1, 2: seq = {seq, 7, 8};
         3:    seq = {seq, 2, 3, 4};
         4:    seq = {seq, 2, 6};
         0:    ;
         default: seq = {seq, 5};
      endcase
      foreach (seq[i]) begin
         int st;
         string t;
         st = seq[i];
         t = (st == 0) ? "R2" : (st == 1) ? "R3" : tag;
         check(t, $sformatf("state op=%0d fn=%0d", op, fn), state_o, st);
         check(t, $sformatf("ctrl op=%0d fn=%0d st=%0d", op, fn, st),
               actual(), model(st, k, op, fn, z, s));
         // R10: write strobes confined to their states
         check("R10", $sformatf("strobes st=%0d", st),
               {reg_wr, mem_wr, ir_wr},
               {(st == 4 || st == 8 || (st == 5 && k == 6)), st == 6, st == 0});
         if (st == 7) check("R11", $sformatf("alu fn op=%0d fn=%0d", op, fn), alu_fn, afn(op, fn));
         @(posedge clk); @(negedge clk);
      end
      // instruction length: the next cycle must be fetch again
      check(tag, $sformatf("length op=%0d fn=%0d", op, fn), state_o, 0);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog: actual=running expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      check("R1", "state in reset", state_o, 0);
      check("R1", "ctrl in reset", actual(), pk(1,3,0,0,1,0,1,0,0,0,0,0,16));
      rst_n = 1'b1;
      check("R1", "state after release", state_o, 0);

      // R4 register ALU forms
      run_instr(0, 32, 0, 0, "R4");
      run_instr(0, 34, 0, 0, "R4");
      run_instr(0, 42, 0, 0, "R4");
      run_instr(0, 36, 0, 0, "R4");
      run_instr(0, 37, 0, 0, "R4");
      run_instr(0, 38, 0, 0, "R4");
      run_instr(0, 39, 1, 1, "R4");
      // R5 immediate forms
      run_instr(15, 0, 0, 0, "R5");
      run_instr(8,  0, 0, 0, "R5");
      run_instr(10, 0, 0, 0, "R5");
      run_instr(12, 0, 0, 0, "R5");
      run_instr(13, 0, 0, 0, "R5");
      run_instr(14, 0, 0, 0, "R5");
      // R6 load, R7 store
      run_instr(35, 0, 0, 0, "R6");
      run_instr(43, 0, 0, 0, "R7");
      // R9 jumps
      run_instr(2, 0, 0, 0, "R9");
      run_instr(3, 0, 0, 0, "R9");
      run_instr(0, 8, 0, 0, "R9");
      run_instr(0, 12, 0, 0, "R9");
      // R8 branches, both outcomes
      run_instr(4, 0, 1, 0, "R8");
      run_instr(4, 0, 0, 1, "R8");
      run_instr(5, 0, 1, 0, "R8");
      run_instr(5, 0, 0, 0, "R8");
      run_instr(1, 0, 0, 1, "R8");
      run_instr(1, 0, 1, 0, "R8");
      // R3 unrecognised codes
      run_instr(63, 0, 0, 0, "R3");
      run_instr(0, 0, 0, 0, "R3");
      run_instr(0, 13, 1, 1, "R3");
      run_instr(35, 0, 0, 0, "R6");

      // R1 reset in the middle of an instruction
      opcode = 6'd0; funct = 6'd32;
      @(posedge clk); @(posedge clk); @(negedge clk);
      check("R1", "state before mid reset", state_o, 7);
      rst_n = 1'b0;
      #1;
      check("R1", "state during mid reset", state_o, 0);
      @(posedge clk); @(negedge clk);
      rst_n = 1'b1;
      check("R1", "state after mid reset", state_o, 0);
      run_instr(43, 0, 0, 0, "R7");

      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule